// File: doc/BRIEF.md
# Lockable Two-Overflow Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. Software programs a 12-bit period field, enables counting and then must refresh the timer regularly. The count advances on a counting strobe, `tick`, which stands for the separate slow counting clock as a one-cycle enable in the bus clock domain. When one full overflow cycle passes without a refresh, the interrupt output rises as an early warning. When a second overflow cycle follows with still no refresh, the reset request output rises and stays high.

Once counting is enabled, the period setting and the enable bit are frozen until a module reset. A refresh can therefore only restart the count. It can never lengthen or stop the timeout. A separate error path lets software raise the reset request at once: it writes a force bit while the error-control bit is clear.

The overflow length is 2^`PRESCALE_LOG2` × (period + 1) ticks. The default prescaler of 2^20 ticks can be scaled down for short simulations.

Top module: `wdt_top`

## Requirements
- R1: The register offsets are: control 0x00 (enable in bit 0), setting 0x04 (period in bits [31:20]), elapsed count 0x08, interrupt/refresh 0x0C (status in bit 0), error control 0x10 (bit 0), error force 0x14. Unused bits, offset 0x14 and unmapped offsets all read as zero.
- R2: While the timer is disabled, a write to 0x04 stores bits [31:20]. While it is enabled, writes to 0x04 are ignored and the stored period is kept.
- R3: Once bit 0 of the control register is set, writing 0 to the control register has no effect until a module reset.
- R4: While the timer is enabled, each `tick` advances the elapsed count by one. While it is disabled, ticks leave the count unchanged. One overflow cycle is 2^PRESCALE_LOG2 × (period + 1) ticks, and the count reads 0 after it wraps.
- R5: `irq` rises on the clock edge that samples the tick completing the first overflow cycle. Bit 0 of 0x0C reads the same state.
- R6: Writing 1 to bit 0 of 0x0C clears both the elapsed count and the interrupt. Writing 0 there changes nothing.
- R7: `rst_req` rises on the tick that completes a second overflow cycle when no refresh came after the first one. It stays high through refreshes until a module reset.
- R8: Any write to 0x08 sets the elapsed count to zero, whatever the data.
- R9: Writing 1 to bit 0 of 0x14 while error-control bit 0 is 0 raises `rst_req` on that edge. When error-control bit 0 is 1, the write is ignored.
- R10: A module reset (`rst_n` low) clears every register, the count, the interrupt, the reset request and the lock.
- R11: A refresh that lands on the same edge as the tick completing an overflow wins: the interrupt stays low and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Module reset, active low, asynchronous |
| tick | input | 1 | Counting strobe, one count per high cycle |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | First-overflow interrupt |
| rst_req | output | 1 | Reset request, sticky |

## Verification
The assertions check on every cycle the invariants that hold whatever the stimulus. These are: the period and enable lock, no movement of the count while disabled, a zero count after each overflow, a sticky interrupt and reset request, and a reset request that rises only after an interrupt or a forced error. Other behaviours need specific stimulus sequences and are shown only by the bench's scenarios. These are the exact tick count at which `irq` and `rst_req` rise, the field layout seen through reads, the way a refresh between overflows breaks the consecutive pair, the collision of a refresh with the completing tick, and the gating of the forced error by its control bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Register byte offsets; software depends on these.
   localparam int unsigned OFF_CTRL = 32'h00;
   localparam int unsigned OFF_SET  = 32'h04;
   localparam int unsigned OFF_ELAP = 32'h08;
   localparam int unsigned OFF_INT  = 32'h0C;
   localparam int unsigned OFF_ECTL = 32'h10;
   localparam int unsigned OFF_EFRC = 32'h14;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_SET,
      SEL_ELAP,
      SEL_INT,
      SEL_ECTL,
      SEL_EFRC
   } wdt_sel_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned PERIOD_W  = 12,
   parameter int unsigned ELAPSED_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 irq,
   input  logic [ELAPSED_W-1:0] elapsed,
   output logic                 en,
   output logic [PERIOD_W-1:0]  period,
   output logic                 refresh,
   output logic                 elap_clr,
   output logic                 force_hit,
   output logic [DATA_W-1:0]    rdata
);

   localparam int unsigned PERIOD_LSB = DATA_W - PERIOD_W;

   wdt_sel_e            sel;
   logic                en_q;
   logic [PERIOD_W-1:0] period_q;
   logic                ectl_q;
   logic                unused_wdata_bits;

   assign unused_wdata_bits = ^wdata;

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFF_SET))  sel = SEL_SET;
      else if (addr == ADDR_W'(OFF_ELAP)) sel = SEL_ELAP;
      else if (addr == ADDR_W'(OFF_INT))  sel = SEL_INT;
      else if (addr == ADDR_W'(OFF_ECTL)) sel = SEL_ECTL;
      else if (addr == ADDR_W'(OFF_EFRC)) sel = SEL_EFRC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         period_q <= '0;
         ectl_q   <= 1'b0;
      end else if (wr_en) begin
         if (sel == SEL_CTRL && wdata[0])
            en_q <= 1'b1;
         if (sel == SEL_SET && !en_q)
            period_q <= wdata[DATA_W-1:PERIOD_LSB];
         if (sel == SEL_ECTL)
            ectl_q <= wdata[0];
      end
   end

   assign refresh   = wr_en && (sel == SEL_INT) && wdata[0];
   assign elap_clr  = wr_en && (sel == SEL_ELAP);
   assign force_hit = wr_en && (sel == SEL_EFRC) && wdata[0] && !ectl_q;

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: rdata[0] = en_q;
         SEL_SET:  rdata[DATA_W-1:PERIOD_LSB] = period_q;
         SEL_ELAP: rdata = DATA_W'(elapsed);
         SEL_INT:  rdata[0] = irq;
         SEL_ECTL: rdata[0] = ectl_q;
         default:  rdata = '0;
      endcase
   end

   assign en     = en_q;
   assign period = period_q;

   // R2
   period_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(period_q));

   // R3
   enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned PERIOD_W      = 12,
   parameter int unsigned PRESCALE_LOG2 = 20,
   localparam int unsigned ELAPSED_W    = PERIOD_W + PRESCALE_LOG2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 tick,
   input  logic                 clr,
   input  logic [PERIOD_W-1:0]  period,
   output logic                 ovf,
   output logic [ELAPSED_W-1:0] elapsed
);

   logic [PERIOD_W-1:0] per_q;
   logic                step;

   assign step = en && tick;

   if (PRESCALE_LOG2 > 0) begin : g_prescaled
      logic [PRESCALE_LOG2-1:0] pre_q;

      assign ovf     = step && (&pre_q) && (per_q == period);
      assign elapsed = {per_q, pre_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_q <= '0;
            pre_q <= '0;
         end else if (clr || ovf) begin
            per_q <= '0;
            pre_q <= '0;
         end else if (step) begin
            {per_q, pre_q} <= {per_q, pre_q} + ELAPSED_W'(1);
         end
      end
   end else begin : g_direct
      assign ovf     = step && (per_q == period);
      assign elapsed = per_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            per_q <= '0;
         else if (clr || ovf)
            per_q <= '0;
         else if (step)
            per_q <= per_q + PERIOD_W'(1);
      end
   end

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(elapsed));

   // R4
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (elapsed == '0));

endmodule

// File: rtl/wdt_ovf_track.sv
module wdt_ovf_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   input  logic refresh,
   input  logic force_hit,
   output logic irq,
   output logic rst_req
);

   logic first_q;
   logic rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         if (refresh)
            first_q <= 1'b0;
         else if (ovf)
            first_q <= 1'b1;
         if (force_hit || (ovf && first_q && !refresh))
            rst_q <= 1'b1;
      end
   end

   assign irq     = first_q;
   assign rst_req = rst_q;

   // R5
   first_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !refresh) |=> irq);

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !refresh) |=> irq);

   // R7
   rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   // R7
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(irq || force_hit));

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned PERIOD_W      = 12,
   parameter int unsigned PRESCALE_LOG2 = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              rst_req
);

   localparam int unsigned ELAPSED_W = PERIOD_W + PRESCALE_LOG2;

   if (ELAPSED_W > DATA_W) begin : g_bad_width
      $error("elapsed count wider than the data bus");
   end
   if (PERIOD_W == 0 || PERIOD_W > DATA_W) begin : g_bad_period
      $error("period field must fit the data bus");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("address too narrow for the register offsets");
   end

   logic                 en;
   logic [PERIOD_W-1:0]  period;
   logic                 refresh;
   logic                 elap_clr;
   logic                 force_hit;
   logic                 ovf;
   logic [ELAPSED_W-1:0] elapsed;

   wdt_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .PERIOD_W  (PERIOD_W),
      .ELAPSED_W (ELAPSED_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .irq       (irq),
      .elapsed   (elapsed),
      .en        (en),
      .period    (period),
      .refresh   (refresh),
      .elap_clr  (elap_clr),
      .force_hit (force_hit),
      .rdata     (rdata)
   );

   wdt_counter #(
      .PERIOD_W      (PERIOD_W),
      .PRESCALE_LOG2 (PRESCALE_LOG2)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .tick    (tick),
      .clr     (refresh || elap_clr),
      .period  (period),
      .ovf     (ovf),
      .elapsed (elapsed)
   );

   wdt_ovf_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovf       (ovf),
      .refresh   (refresh),
      .force_hit (force_hit),
      .irq       (irq),
      .rst_req   (rst_req)
   );

endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          rst_req;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   wdt_top #(
      .DATA_W(DW), .ADDR_W(AW), .PERIOD_W(12), .PRESCALE_LOG2(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic ticks(int n);
      if (n > 0) begin
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic t_reset_state();
      logic [DW-1:0] v;
      do_reset();
      for (int a = 0; a < 6; a++) begin
         rd(AW'(a * 4), v);
         check("R10", "register after reset", v, 0);
      end
      check("R10", "irq after reset", {31'b0, irq}, 0);
      check("R10", "rst_req after reset", {31'b0, rst_req}, 0);
   endtask

   task automatic t_fields_lock();
      logic [DW-1:0] v;
      do_reset();
      wr(5'h04, 32'hFFFF_FFFF);
      rd(5'h04, v); check("R1", "period field only", v, 32'hFFF0_0000);
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, v); check("R1", "control bit0 only", v, 32'h1);
      wr(5'h04, 32'h1230_0000);
      rd(5'h04, v); check("R2", "period locked", v, 32'hFFF0_0000);
      wr(5'h00, 32'h0);
      rd(5'h00, v); check("R3", "enable sticky", v, 32'h1);
      ticks(3);
      rd(5'h08, v); check("R4", "elapsed after 3 ticks", v, 3);
      wr(5'h08, 32'hABC);
      rd(5'h08, v); check("R8", "elapsed cleared by write", v, 0);
      rd(5'h18, v); check("R1", "unmapped reads zero", v, 0);
   endtask

   task automatic t_overflows();
      logic [DW-1:0] v;
      do_reset();
      wr(5'h04, 32'h0010_0000);      // period 1 -> 8 ticks
      wr(5'h08, 32'h0);
      ticks(3);
      rd(5'h08, v); check("R4", "no count while disabled", v, 0);
      wr(5'h00, 32'h1);
      ticks(5);
      rd(5'h08, v); check("R4", "count 5", v, 5);
      ticks(2);
      check("R5", "irq before overflow", {31'b0, irq}, 0);
      ticks(1);
      check("R5", "irq at first overflow", {31'b0, irq}, 1);
      rd(5'h0C, v); check("R5", "status bit", v, 1);
      rd(5'h08, v); check("R4", "count wrapped", v, 0);
      check("R7", "no reset after one overflow", {31'b0, rst_req}, 0);
      wr(5'h0C, 32'h0);
      check("R6", "zero write keeps irq", {31'b0, irq}, 1);
      ticks(2);
      wr(5'h0C, 32'h1);
      check("R6", "refresh clears irq", {31'b0, irq}, 0);
      rd(5'h08, v); check("R6", "refresh clears count", v, 0);
      ticks(8);
      check("R5", "irq again", {31'b0, irq}, 1);
      ticks(7);
      check("R7", "reset not yet", {31'b0, rst_req}, 0);
      ticks(1);
      check("R7", "reset after second overflow", {31'b0, rst_req}, 1);
      wr(5'h0C, 32'h1);
      check("R7", "reset sticky over refresh", {31'b0, rst_req}, 1);
      do_reset();
      check("R10", "reset clears rst_req", {31'b0, rst_req}, 0);
      rd(5'h04, v); check("R10", "reset clears period", v, 0);
      wr(5'h04, 32'h0050_0000);
      rd(5'h04, v); check("R10", "lock released", v, 32'h0050_0000);
   endtask

   task automatic t_refresh_race();
      logic [DW-1:0] v;
      do_reset();
      wr(5'h00, 32'h1);              // period 0 -> 4 ticks
      ticks(3);
      tick = 1'b1;
      wr(5'h0C, 32'h1);
      tick = 1'b0;
      check("R11", "irq stays low", {31'b0, irq}, 0);
      rd(5'h08, v); check("R11", "count zero", v, 0);
      ticks(4);
      check("R5", "irq after fresh cycle", {31'b0, irq}, 1);
      ticks(3);
      wr(5'h0C, 32'h1);
      ticks(4);
      check("R7", "refresh breaks the pair", {31'b0, rst_req}, 0);
      check("R5", "irq after new cycle", {31'b0, irq}, 1);
   endtask

   task automatic t_force();
      logic [DW-1:0] v;
      do_reset();
      wr(5'h10, 32'h1);
      rd(5'h10, v); check("R1", "error control bit", v, 1);
      wr(5'h14, 32'h1);
      check("R9", "force blocked", {31'b0, rst_req}, 0);
      wr(5'h10, 32'h0);
      wr(5'h14, 32'h0);
      check("R9", "force zero ignored", {31'b0, rst_req}, 0);
      wr(5'h14, 32'h1);
      check("R9", "force raises reset", {31'b0, rst_req}, 1);
      rd(5'h14, v); check("R1", "force reads zero", v, 0);
   endtask

   initial begin
      t_reset_state();
      t_fields_lock();
      t_overflows();
      t_refresh_race();
      t_force();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule